// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is a register-mapped sequencer for a successive-approximation analog-to-digital converter. Software arms a conversion with a single write to the control register. The block raises the converter power and waits a programmable number of clock periods for the analog front end to settle. It then issues a one-cycle start pulse and resolves the result one bit per clock, from the most significant bit down. The comparator answer for each trial code comes back on a single input.

When the last bit is decided, the block stores the result in the data register, drops busy and sets the interrupt status. Software collects the value and writes zero to control, which clears the interrupt and removes converter power. The same zero write is the abort path. Software uses it when a conversion overruns its timeout, and it is honoured in any phase of the sequence.

Register reads are combinational from a 4-bit byte address. Writes are single-cycle strobes.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset all outputs are low, and the data, status, control and delay registers all read 0.
- R2: The registers are at these byte offsets:
  - Data at 0x00: the result, zero-extended above RES_W bits.
  - Status at 0x04: bit 0 is busy.
  - Control at 0x08: bit 6 is the interrupt status (read-only), bit 5 is the interrupt enable, bit 3 is power, and bits 2:0 are the channel. All other bits read 0.
  - Delay at 0x0C: 6 bits, with the higher bits reading 0.
  - Writes to data and status have no effect.
- R3: A control write with bit 3 set, made while idle, arms a conversion. From the next cycle `adc_pwr_o` is 1, busy reads 1, and `adc_chan_o` shows the written channel.
- R4: `adc_start_o` is high for exactly one cycle. If the arming write takes effect at clock edge E, the pulse falls in the D-th cycle after E, counting the cycle right after E as cycle 0, where D is the delay register value. D=0 therefore starts in the cycle right after the write.
- R5: In the k-th cycle after the start pulse (k=0..RES_W-1), `adc_trial_o` carries the bits already decided, plus a 1 at bit RES_W-1-k. A trial bit is kept when `adc_cmp_i` is 1 in that cycle, meaning the trial code is at or below the input.
- R6: Busy falls RES_W+1 cycles after the start cycle. On that same edge the data register takes the result and control bit 6 sets.
- R7: `irq_o` is high exactly when control bit 6 and control bit 5 are both set.
- R8: A control write with bit 3 clear aborts the sequence in any phase. From the next cycle the block is idle, with power off, interrupt status clear and `irq_o` low. No start pulse follows, and the data register keeps its previous value.
- R9: A control write with bit 3 set, made while busy, updates the enable and channel fields but does not restart the sequence. `adc_chan_o` holds the channel latched at arming until the conversion ends.
- R10: Any control write clears the interrupt status, so re-arming after a finished conversion drops `irq_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| adc_pwr_o | output | 1 | Converter power enable |
| adc_chan_o | output | 3 | Latched input channel select |
| adc_start_o | output | 1 | Start-of-conversion pulse |
| adc_trial_o | output | RES_W | Trial code presented to the comparator |
| adc_cmp_i | input | 1 | Comparator: 1 when trial code is at or below the input |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a control write that arrives mid-sequence: an abort in the middle of the settle count or the bit search, or a second power-set write while busy. Either one must leave the latched channel, the data register and the start pulse untouched. The bench places these writes at chosen cycle offsets after arming, using long settle delays and counted waits into the search. It then watches `adc_start_o` for a long quiet window and reads the data register back. A behavioural comparator, built as a compare of the trial code against a bench-held input value, lets every vector predict the exact result and each per-bit trial code.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned DLY_W = 6;
  localparam int unsigned CH_W  = 3;

  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_STAT = 2'd1;
  localparam logic [1:0] OFF_CTRL = 2'd2;
  localparam logic [1:0] OFF_DLY  = 2'd3;

  localparam int unsigned CTRL_PWR = 3;
  localparam int unsigned CTRL_IEN = 5;
  localparam int unsigned CTRL_IST = 6;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_st_e;
endpackage

// File: rtl/sar_search.sv
module sar_search #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             last_o,
  output logic [RES_W-1:0] result_o
);
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] acc_q, mask_q;

  assign trial_o  = acc_q | mask_q;
  assign last_o   = mask_q[0];
  assign result_o = cmp_i ? (acc_q | mask_q) : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      acc_q  <= '0;
      mask_q <= MSB_ONE;
    end else if (step_i) begin
      if (cmp_i) acc_q <= acc_q | mask_q;
      mask_q <= mask_q >> 1;
    end
  end
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
  import sar_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_wr_i,
  input  logic            wr_pwr_i,
  input  logic [CH_W-1:0] wr_chan_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic            last_i,
  output logic            busy_o,
  output logic            start_o,
  output logic            step_o,
  output logic            done_o,
  output logic [CH_W-1:0] chan_o
);
  seq_st_e          st_q;
  logic [DLY_W-1:0] cnt_q;
  logic [CH_W-1:0]  chan_q;
  logic             abort, arm;

  assign abort   = ctrl_wr_i && !wr_pwr_i;
  assign arm     = ctrl_wr_i && wr_pwr_i && (st_q == ST_IDLE);
  assign busy_o  = (st_q != ST_IDLE);
  assign start_o = (st_q == ST_SETTLE) && (cnt_q == '0) && !abort;
  assign step_o  = (st_q == ST_CONV) && !abort;
  assign done_o  = step_o && last_i;
  assign chan_o  = chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      chan_q <= '0;
    end else if (abort) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (arm) begin
          st_q   <= ST_SETTLE;
          cnt_q  <= dly_i;
          chan_q <= wr_chan_i;
        end
        ST_SETTLE: begin
          if (cnt_q == '0) st_q <= ST_CONV;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_CONV: if (last_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [RES_W-1:0]  result_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ctrl_wr_o,
  output logic              pwr_o,
  output logic              ien_o,
  output logic              ist_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [DLY_W-1:0]  dly_o
);
  logic [RES_W-1:0] data_q;
  logic             dly_wr;

  assign ctrl_wr_o = wr_i && (addr_i[3:2] == OFF_CTRL);
  assign dly_wr    = wr_i && (addr_i[3:2] == OFF_DLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_o  <= 1'b0;
      ien_o  <= 1'b0;
      chan_o <= '0;
      dly_o  <= '0;
      data_q <= '0;
      ist_o  <= 1'b0;
    end else begin
      if (ctrl_wr_o) begin
        pwr_o  <= wdata_i[CTRL_PWR];
        ien_o  <= wdata_i[CTRL_IEN];
        chan_o <= wdata_i[CH_W-1:0];
      end
      if (dly_wr) dly_o <= wdata_i[DLY_W-1:0];
      if (done_i) data_q <= result_i;
      if (done_i)         ist_o <= 1'b1;
      else if (ctrl_wr_o) ist_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i[3:2])
      OFF_DATA: rdata_o[RES_W-1:0] = data_q;
      OFF_STAT: rdata_o[0]         = busy_i;
      OFF_CTRL: begin
        rdata_o[CTRL_IST] = ist_o;
        rdata_o[CTRL_IEN] = ien_o;
        rdata_o[CTRL_PWR] = pwr_o;
        rdata_o[CH_W-1:0] = chan_o;
      end
      default:  rdata_o[DLY_W-1:0] = dly_o;
    endcase
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             adc_pwr_o,
  output logic [2:0]       adc_chan_o,
  output logic             adc_start_o,
  output logic [RES_W-1:0] adc_trial_o,
  input  logic             adc_cmp_i,
  output logic             irq_o
);
  logic             ctrl_wr, irq_en, irq_stat, busy, step, done, last;
  logic [CH_W-1:0]  reg_chan;
  logic [DLY_W-1:0] dly;
  logic [RES_W-1:0] result;

  sar_regs #(.RES_W(RES_W), .DATA_W(32)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy),
    .done_i    (done),
    .result_i  (result),
    .rdata_o   (reg_rdata_o),
    .ctrl_wr_o (ctrl_wr),
    .pwr_o     (adc_pwr_o),
    .ien_o     (irq_en),
    .ist_o     (irq_stat),
    .chan_o    (reg_chan),
    .dly_o     (dly)
  );

  sar_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (ctrl_wr),
    .wr_pwr_i  (reg_wdata_i[CTRL_PWR]),
    .wr_chan_i (reg_wdata_i[CH_W-1:0]),
    .dly_i     (dly),
    .last_i    (last),
    .busy_o    (busy),
    .start_o   (adc_start_o),
    .step_o    (step),
    .done_o    (done),
    .chan_o    (adc_chan_o)
  );

  sar_search #(.RES_W(RES_W)) u_search (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (adc_start_o),
    .step_i   (step),
    .cmp_i    (adc_cmp_i),
    .trial_o  (adc_trial_o),
    .last_o   (last),
    .result_o (result)
  );

  assign irq_o = irq_stat && irq_en;
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_i,
  input logic [3:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        busy_i,
  input logic        ist_i,
  input logic        start_i,
  input logic        pwr_i,
  input logic [2:0]  chan_i,
  input logic        irq_i
);
  logic abort_wr;
  assign abort_wr = reg_wr_i && (reg_addr_i[3:2] == 2'd2) && !reg_wdata_i[3];

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !start_i); // R4
  AST_IST_ON_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ist_i) |-> $fell(busy_i)); // R6
  AST_CHAN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(chan_i)); // R9
  AST_PWR_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> pwr_i); // R3
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_wr |=> (!busy_i && !irq_i && !pwr_i)); // R8
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .busy_i      (busy),
  .ist_i       (irq_stat),
  .start_i     (adc_start_o),
  .pwr_i       (adc_pwr_o),
  .chan_i      (adc_chan_o),
  .irq_i       (irq_o)
);

// File: tb/sar_seq_ctrl_test.sv
module sar_seq_ctrl_test;
  localparam int W = 10;
  localparam int NV = 6;
  // {en[21], chan[20:18], dly[17:12], vin[11:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 3'd0, 6'd8,  12'd0},
    {1'b1, 3'd1, 6'd0,  12'd1023},
    {1'b0, 3'd2, 6'd3,  12'd512},
    {1'b1, 3'd7, 6'd1,  12'd511},
    {1'b1, 3'd4, 6'd63, 12'd341},
    {1'b0, 3'd5, 6'd5,  12'd682}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic pwr, start, irq, cmp;
  logic [2:0] chan;
  logic [W-1:0] trial;
  int vin = 0;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;
  assign cmp = (int'(trial) <= vin);

  sar_seq_ctrl #(.RES_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .adc_pwr_o(pwr),
    .adc_chan_o(chan), .adc_start_o(start), .adc_trial_o(trial),
    .adc_cmp_i(cmp), .irq_o(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_start(output int k);
    k = 0;
    while (!start && k < 200) begin @(posedge clk); #1; k++; end
  endtask

  task automatic wait_idle(output int k);
    addr = 4'h4; #1; k = 1;
    while (rdata[0] && k < 200) begin @(posedge clk); #1; k++; end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int k;
    #35; rst_n = 1'b1;
    // R1 reset state
    check("R1", "pwr", {31'd0, pwr}, 0);
    check("R1", "start", {31'd0, start}, 0);
    check("R1", "irq", {31'd0, irq}, 0);
    check("R1", "chan", {29'd0, chan}, 0);
    for (int a = 0; a < 16; a += 4) begin
      reg_read(4'(a), r); check("R1", "reg read", r, 0);
    end

    // R2 field masking, writes to read-only registers ignored
    reg_write(4'hC, 32'hFFFF_FFFF); reg_read(4'hC, r); check("R2", "dly mask", r, 32'h3F);
    reg_write(4'h8, 32'hFFFF_FFF7); reg_read(4'h8, r); check("R2", "ctrl mask", r, 32'h27);
    reg_write(4'h0, 32'hFFFF_FFFF); reg_read(4'h0, r); check("R2", "data ro", r, 0);
    reg_write(4'h4, 32'hFFFF_FFFF); reg_read(4'h4, r); check("R2", "stat ro", r, 0);
    reg_write(4'h8, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic en; logic [2:0] ch; logic [5:0] d;
      en = VEC[i][21]; ch = VEC[i][20:18]; d = VEC[i][17:12];
      vin = int'(VEC[i][11:0]);
      reg_write(4'hC, {26'd0, d});
      reg_write(4'h8, {26'd0, en, 2'b01, ch});
      check("R3", "pwr", {31'd0, pwr}, 1);
      check("R3", "chan", {29'd0, chan}, {29'd0, ch});
      addr = 4'h4; #1; check("R3", "busy", rdata, 1);
      wait_start(k); check("R4", "start delay", k, d);
      @(posedge clk); #1;
      check("R4", "start width", {31'd0, start}, 0);
      check("R5", "first trial", {22'd0, trial}, 32'h200);
      wait_idle(k); check("R6", "busy fall", k, W + 1);
      check("R7", "irq", {31'd0, irq}, {31'd0, en});
      reg_read(4'h0, r); check("R6", "result", r, vin);
      reg_read(4'h8, r); check("R6", "ctrl stat", r, {25'd0, 1'b1, en, 2'b01, ch});
      reg_write(4'h8, 0);
      check("R8", "irq clear", {31'd0, irq}, 0);
      check("R8", "pwr off", {31'd0, pwr}, 0);
    end

    // R5 full trial sequence
    vin = 32'h2AA;
    reg_write(4'hC, 0); reg_write(4'h8, 32'h28);
    wait_start(k);
    for (int b = 0; b < W; b++) begin
      logic [W-1:0] hi;
      @(posedge clk); #1;
      hi = W'(vin) & ~W'((1 << (W - b)) - 1);
      check("R5", "trial step", {22'd0, trial}, {22'd0, hi | W'(1 << (W - 1 - b))});
    end
    @(posedge clk); #1;
    check("R7", "irq set", {31'd0, irq}, 1);

    // R10 re-arm clears status
    reg_write(4'h8, 32'h29);
    check("R10", "irq drop", {31'd0, irq}, 0);
    reg_read(4'h8, r); check("R10", "ctrl stat", r, 32'h29);
    wait_start(k); wait_idle(k);
    reg_write(4'h8, 0);

    // R9 rewrite while busy
    vin = 300;
    reg_write(4'hC, 2); reg_write(4'h8, 32'h2D);
    reg_write(4'h8, 32'h2A);
    check("R9", "chan held", {29'd0, chan}, 5);
    wait_start(k); check("R9", "no restart", k, 1);
    @(posedge clk); #1; reg_write(4'h8, 32'h2A);
    check("R9", "chan held conv", {29'd0, chan}, 5);
    wait_idle(k);
    reg_read(4'h0, r); check("R9", "result", r, 300);
    reg_read(4'h8, r); check("R9", "ctrl fields", r, 32'h6A);
    reg_write(4'h8, 0);

    // R8 abort during settle
    vin = 77;
    reg_write(4'hC, 40); reg_write(4'h8, 32'h2B);
    repeat (5) @(posedge clk);
    reg_write(4'h8, 0);
    reg_read(4'h4, r); check("R8", "busy settle abort", r, 0);
    k = 0;
    for (int c = 0; c < 60; c++) begin @(posedge clk); #1; if (start) k++; end
    check("R8", "no start", k, 0);
    reg_read(4'h0, r); check("R8", "data kept", r, 300);

    // R8 abort during search
    reg_write(4'hC, 0); reg_write(4'h8, 32'h2B);
    wait_start(k);
    repeat (4) @(posedge clk);
    reg_write(4'h8, 0);
    reg_read(4'h4, r); check("R8", "busy conv abort", r, 0);
    repeat (20) @(posedge clk);
    #1; check("R8", "irq after abort", {31'd0, irq}, 0);
    reg_read(4'h0, r); check("R8", "data kept conv", r, 300);
    reg_read(4'h8, r); check("R8", "ctrl cleared", r, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule